// File: doc/BRIEF.md
# Entropy Source Bring-Up Sequencer

This block brings up a true random number generator after power-on. A single `start` pulse launches a bring-up session. If the generator reports that its first state handle is already instantiated, the session ends at once with success and touches nothing. Otherwise the sequencer programs the entropy source through a series of register-write strobes. It enters program mode, sets the sample length and the frequency limits, selects raw sampling and returns to run mode. It then asks the surrounding logic to run an instantiation job.

Each job ends with a status word and the instantiated flag. A job that fails makes the sequencer lengthen the entropy sample by a fixed step and try again. The minimum frequency limit is rescaled along with the sample length. The retries stop when the lengthened sample would reach the configured ceiling. When a job succeeds, the sequencer turns on faster random-data reads and finishes. The outcome is reported as a one-cycle `done` pulse plus a `fail` level.

States: `S_IDLE` (wait for start), `S_PRGM_ON`, `S_DELAY`, `S_FMIN`, `S_FMAX`, `S_RAW`, `S_PRGM_OFF` (one register write each), `S_REQ` (job request), `S_WAIT` (wait for job completion), `S_EVAL` (judge the attempt), `S_FAST` (fast-read enable write) and `S_FIN` (done pulse). The transitions are as follows:
- idle→fin when start arrives and the handle is already instantiated; idle→prgm_on when start arrives otherwise.
- Each write state→the next write state; prgm_off→req; req→wait.
- wait→eval on job completion.
- eval→fast on a good attempt; eval→prgm_on on a bad attempt that has retries left; eval→fin on a bad attempt with retries exhausted.
- fast→fin, and fin→idle.

Top module: `trng_instantiate_seq`

## Requirements
- R1: When `start` is seen in idle with `inst_ready` high, `done` pulses on the next cycle with `fail` low, and no write strobe or job request is issued.
- R2: Each attempt issues writes on consecutive cycles, one per cycle, in this order of `wr_kind` codes: 0 program-mode on, 1 entropy delay, 2 minimum frequency, 3 maximum-frequency check off, 4 raw sampling for shifter and checker, 5 program-mode off. `job_req` is high for one cycle right after code 5.
- R3: The entropy delay written in the first attempt of a session equals `DLY_START` (default 3200), carried in a `DLY_W`-bit (16) value.
- R4: The minimum-frequency write carries the entropy delay of the same attempt shifted right by two.
- R5: An attempt fails when the captured `job_status` is nonzero or `inst_ready` is low after completion. Both conditions cause a retry.
- R6: After a failed attempt the delay grows by `DLY_STEP` (400) and a new attempt starts. If the grown delay would be at least `DLY_LIMIT` (12800), no retry follows. Instead `done` pulses with `fail` high and no fast-read write is issued. With the defaults, 24 attempts are made, and the last one uses a delay of 12400.
- R7: After a successful attempt one write of code 6 (fast-read enable) is issued, and the next cycle `done` pulses with `fail` low.
- R8: `done` lasts exactly one cycle. `fail` holds its value until the next accepted `start`.
- R9: `start` while a session runs and `job_done` outside the wait state have no effect on the outputs or on the write sequence.
- R10: After reset all outputs are low and the sequencer accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up session (sampled in idle) |
| inst_ready | input | 1 | State handle 0 instantiated flag from the generator |
| job_done | input | 1 | Instantiation job completion strobe |
| job_status | input | ST_W (8) | Job completion status, zero means good |
| wr_valid | output | 1 | Register-write strobe |
| wr_kind | output | 3 | Which register field is written (codes in R2, R7) |
| wr_value | output | DLY_W (16) | Value for the write (delay or frequency minimum, else zero) |
| job_req | output | 1 | Request to run the instantiation job |
| done | output | 1 | One-cycle session end pulse |
| fail | output | 1 | Session ended without instantiation |

## Verification
A wrong state register shows up on the write strobes within one cycle. A skipped or repeated state breaks the fixed code order, or puts a job request where a write belongs. A corrupted delay counter shows up on the next delay or frequency-minimum write, which the bench compares against its own running model of the delay. A mistake in the retry decision appears within two cycles of job completion: the wrong choice among fast-read write, new program-mode write or failing `done` is visible immediately. An off-by-one in the ceiling shows as one attempt too many or too few in the exhausting session.

// File: rtl/trng_seq_pkg.sv
package trng_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRGM_ON,
        S_DELAY,
        S_FMIN,
        S_FMAX,
        S_RAW,
        S_PRGM_OFF,
        S_REQ,
        S_WAIT,
        S_EVAL,
        S_FAST,
        S_FIN
    } seq_state_t;

    typedef enum logic [2:0] {
        WK_PRGM_SET = 3'd0,
        WK_DELAY    = 3'd1,
        WK_FMIN     = 3'd2,
        WK_FMAX_OFF = 3'd3,
        WK_RAW      = 3'd4,
        WK_PRGM_CLR = 3'd5,
        WK_FAST_RD  = 3'd6
    } wr_kind_t;

endpackage

// File: rtl/trng_delay_sched.sv
module trng_delay_sched #(
    parameter int DLY_W     = 16,
    parameter int DLY_START = 3200,
    parameter int DLY_STEP  = 400,
    parameter int DLY_LIMIT = 12800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    output logic [DLY_W-1:0] delay,
    output logic [DLY_W-1:0] fmin,
    output logic             last
);
    localparam int SUM_W = DLY_W + 1;

    logic [DLY_W-1:0] delay_q;
    logic [SUM_W-1:0] grown;

    assign grown = {1'b0, delay_q} + SUM_W'(DLY_STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            delay_q <= DLY_W'(DLY_START);
        else if (load)
            delay_q <= DLY_W'(DLY_START);
        else if (advance)
            delay_q <= grown[DLY_W-1:0];
    end

    assign delay = delay_q;
    assign fmin  = delay_q >> 2;
    assign last  = grown >= SUM_W'(DLY_LIMIT);

endmodule

// File: rtl/trng_job_eval.sv
module trng_job_eval #(
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [ST_W-1:0] job_status,
    input  logic            inst_ready,
    output logic            attempt_ok
);
    logic status_bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status_bad_q <= 1'b0;
        else if (capture)
            status_bad_q <= |job_status;
    end

    assign attempt_ok = !status_bad_q && inst_ready;

endmodule

// File: rtl/trng_instantiate_seq.sv
module trng_instantiate_seq
    import trng_seq_pkg::*;
#(
    parameter int DLY_W     = 16,
    parameter int ST_W      = 8,
    parameter int DLY_START = 3200,
    parameter int DLY_STEP  = 400,
    parameter int DLY_LIMIT = 12800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             inst_ready,
    input  logic             job_done,
    input  logic [ST_W-1:0]  job_status,
    output logic             wr_valid,
    output logic [2:0]       wr_kind,
    output logic [DLY_W-1:0] wr_value,
    output logic             job_req,
    output logic             done,
    output logic             fail
);
    seq_state_t       state_q, state_d;
    logic             accept, load, advance, capture;
    logic             attempt_ok, last;
    logic             fail_q;
    logic [DLY_W-1:0] delay, fmin;

    assign accept  = (state_q == S_IDLE) && start;
    assign load    = accept;
    assign capture = (state_q == S_WAIT) && job_done;
    assign advance = (state_q == S_EVAL) && !attempt_ok && !last;

    trng_delay_sched #(
        .DLY_W     (DLY_W),
        .DLY_START (DLY_START),
        .DLY_STEP  (DLY_STEP),
        .DLY_LIMIT (DLY_LIMIT)
    ) sched_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .delay   (delay),
        .fmin    (fmin),
        .last    (last)
    );

    trng_job_eval #(
        .ST_W (ST_W)
    ) eval_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .job_status (job_status),
        .inst_ready (inst_ready),
        .attempt_ok (attempt_ok)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = inst_ready ? S_FIN : S_PRGM_ON;
            S_PRGM_ON:  state_d = S_DELAY;
            S_DELAY:    state_d = S_FMIN;
            S_FMIN:     state_d = S_FMAX;
            S_FMAX:     state_d = S_RAW;
            S_RAW:      state_d = S_PRGM_OFF;
            S_PRGM_OFF: state_d = S_REQ;
            S_REQ:      state_d = S_WAIT;
            S_WAIT:     if (job_done) state_d = S_EVAL;
            S_EVAL: begin
                if (attempt_ok)
                    state_d = S_FAST;
                else if (last)
                    state_d = S_FIN;
                else
                    state_d = S_PRGM_ON;
            end
            S_FAST:     state_d = S_FIN;
            S_FIN:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fail_q <= 1'b0;
        else if (accept)
            fail_q <= 1'b0;
        else if (state_q == S_EVAL && !attempt_ok && last)
            fail_q <= 1'b1;
    end

    always_comb begin
        wr_valid = 1'b0;
        wr_kind  = 3'(WK_PRGM_SET);
        wr_value = '0;
        job_req  = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_PRGM_ON: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_PRGM_SET);
            end
            S_DELAY: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_DELAY);
                wr_value = delay;
            end
            S_FMIN: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_FMIN);
                wr_value = fmin;
            end
            S_FMAX: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_FMAX_OFF);
            end
            S_RAW: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_RAW);
            end
            S_PRGM_OFF: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_PRGM_CLR);
            end
            S_REQ:  job_req = 1'b1;
            S_FAST: begin
                wr_valid = 1'b1;
                wr_kind  = 3'(WK_FAST_RD);
            end
            S_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    assign fail = fail_q;

endmodule

// File: rtl/trng_seq_chk.sv
module trng_seq_chk #(
    parameter int DLY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [2:0]       wr_kind,
    input logic [DLY_W-1:0] wr_value,
    input logic             job_req,
    input logic             done,
    input logic             fail
);
    // R2
    prgm_then_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_kind == 3'd0) |=> (wr_valid && wr_kind == 3'd1));

    // R4
    fmin_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_kind == 3'd2) |->
            ($past(wr_valid) && $past(wr_kind) == 3'd1 && wr_value == ($past(wr_value) >> 2)));

    // R2
    req_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_req |-> ($past(wr_valid) && $past(wr_kind) == 3'd5));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    fast_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_kind == 3'd6) |=> (done && !fail));

    // R9
    exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, job_req, done}));

endmodule

bind trng_instantiate_seq trng_seq_chk #(.DLY_W(DLY_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_kind  (wr_kind),
    .wr_value (wr_value),
    .job_req  (job_req),
    .done     (done),
    .fail     (fail)
);

// File: tb/trng_instantiate_seq_tb_top.sv
`timescale 1ns/1ps
module trng_instantiate_seq_tb_top;
    localparam int DLY_W = 16;
    localparam int ST_W  = 8;
    localparam int START = 3200;
    localparam int STEP  = 400;
    localparam int LIMIT = 12800;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             inst_ready = 1'b0;
    logic             job_done = 1'b0;
    logic [ST_W-1:0]  job_status = '0;
    logic             wr_valid;
    logic [2:0]       wr_kind;
    logic [DLY_W-1:0] wr_value;
    logic             job_req;
    logic             done;
    logic             fail;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    trng_instantiate_seq #(
        .DLY_W(DLY_W), .ST_W(ST_W), .DLY_START(START), .DLY_STEP(STEP), .DLY_LIMIT(LIMIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .inst_ready(inst_ready),
        .job_done(job_done), .job_status(job_status), .wr_valid(wr_valid),
        .wr_kind(wr_kind), .wr_value(wr_value), .job_req(job_req),
        .done(done), .fail(fail)
    );

    function automatic int attempts_allowed();
        int d = START;
        int n = 1;
        while (d + STEP < LIMIT) begin
            d += STEP;
            n++;
        end
        return n;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_wr(int kind, int value, string req);
        chk(wr_valid == 1'b1, req, "wr_valid", int'(wr_valid), 1);
        chk(int'(wr_kind) == kind, req, "wr_kind", int'(wr_kind), kind);
        chk(int'(wr_value) == value, req, "wr_value", int'(wr_value), value);
        chk(!job_req && !done, req, "req/done during write", int'({job_req, done}), 0);
    endtask

    task automatic expect_quiet(string req);
        chk(!wr_valid && !job_req && !done, req, "quiet outputs",
            int'({wr_valid, job_req, done}), 0);
    endtask

    // fmode: 0 random, 1 bad status, 2 handle flag clear
    task automatic run_session(int n_fail, int lat, int fmode, bit poke_busy);
        int d = START;
        int k = 0;
        bit ok;
        bit bad_status;
        inst_ready = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        forever begin
            expect_wr(0, 0, "R2");
            if (poke_busy && k == 0) start = 1'b1;   // R9: ignored while busy
            @(negedge clk) start = 1'b0;
            expect_wr(1, d, (k == 0) ? "R3" : "R6");
            @(negedge clk) expect_wr(2, d >> 2, "R4");
            @(negedge clk) expect_wr(3, 0, "R2");
            @(negedge clk) expect_wr(4, 0, "R2");
            @(negedge clk) expect_wr(5, 0, "R2");
            @(negedge clk) chk(job_req && !wr_valid, "R2", "job_req", int'(job_req), 1);
            for (int i = 0; i <= lat; i++) begin
                @(negedge clk) expect_quiet("R9");
            end
            ok = (k >= n_fail);
            bad_status = (fmode == 1) || (fmode == 0 && ($urandom % 2 == 0));
            job_done = 1'b1;
            if (ok) begin
                job_status = '0;
                inst_ready = 1'b1;
            end else if (bad_status) begin
                job_status = ST_W'(1 + ($urandom % 255));
                inst_ready = 1'b1;
            end else begin
                job_status = '0;
                inst_ready = 1'b0;
            end
            @(negedge clk) begin
                job_done = 1'b0;
                job_status = ST_W'($urandom);
            end
            expect_quiet("R5");
            @(negedge clk);
            if (ok) begin
                expect_wr(6, 0, "R7");
                @(negedge clk) chk(done && !fail, "R7", "done&&!fail", int'({done, fail}), 2);
                @(negedge clk) chk(!done && !fail, "R8", "done drops", int'({done, fail}), 0);
                break;
            end else if (d + STEP >= LIMIT) begin
                chk(done && fail && !wr_valid, "R6", "exhausted done/fail",
                    int'({done, fail, wr_valid}), 6);
                chk(k + 1 == attempts_allowed(), "R6", "attempt count", k + 1, attempts_allowed());
                @(negedge clk) chk(!done && fail, "R8", "fail held", int'({done, fail}), 1);
                break;
            end else begin
                chk(!done, "R5", "retry not done", int'(done), 0);
                d += STEP;
                k++;
            end
        end
        // R9: stray completion while idle
        job_done = 1'b1;
        @(negedge clk) expect_quiet("R9");
        job_done = 1'b0;
        @(negedge clk) expect_quiet("R9");
    endtask

    task automatic run_preinst();
        inst_ready = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done && !fail, "R1", "immediate done", int'({done, fail}), 2);
        chk(!wr_valid && !job_req, "R1", "no writes", int'({wr_valid, job_req}), 0);
        @(negedge clk) chk(!done, "R8", "done one cycle", int'(done), 0);
        expect_quiet("R1");
        inst_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_7A11));
        repeat (3) @(negedge clk);
        expect_quiet("R10");
        chk(!fail, "R10", "fail in reset", int'(fail), 0);
        rst_n = 1'b1;
        @(negedge clk) expect_quiet("R10");
        run_preinst();
        run_session(0, 0, 1, 1'b1);
        run_session(2, 3, 1, 1'b0);
        run_session(3, 1, 2, 1'b0);
        run_session(100, 0, 0, 1'b0);
        run_preinst();
        run_session(100, 2, 2, 1'b0);
        run_session(attempts_allowed() - 1, 0, 0, 1'b0);
        for (int s = 0; s < 10; s++) begin
            if ($urandom % 5 == 0)
                run_preinst();
            else
                run_session(int'($urandom % (attempts_allowed() + 3)), int'($urandom % 6), 0,
                            ($urandom % 2) == 1);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule